// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block watches the access strobes of an 8K x 8 static RAM port and picks out a fixed six-step pattern of chip-enable-qualified reads. The pattern unlocks a copy of the whole array into nonvolatile cells (store) or a copy back from them (recall). The first five addresses are the same for both commands. Only the sixth read decides which request is raised. Any foreign access in the middle of the pattern cancels it, so normal software traffic can never trigger a transfer by accident.

The detector has one input event per access: `acc_valid` is high for exactly one clock per chip-enable-controlled cycle. `acc_write` tells a write from a read, and the output-enable level is not an input at all. When the pattern completes, a one-clock request pulse goes to the nonvolatile engine. The detector then holds `nv_lock` high, and the surrounding logic uses it to disable the array port. The lock stays high until the engine reports completion on `nv_done`.

There is no data stream through this block. Every pin is a plain control or status signal with no valid/ready handshake, and none can apply back-pressure.

Top module: `nvc_detect`

## Requirements
- R1: Out of reset `seq_step` is 0 and `store_req`, `recall_req` and `nv_lock` are low.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, advance `seq_step` to 1, 2, 3, 4 and 5. `seq_step` counts accepted steps and updates on the clock after each access. Idle cycles between accesses have no effect.
- R3: At `seq_step` 5, a read of 0x0F0F raises `store_req` for one clock on the clock after that read, and `seq_step` returns to 0. This happens whether or not any write occurred before.
- R4: At `seq_step` 5, a read of 0x0F0E raises `recall_req` for one clock on the clock after that read, and `seq_step` returns to 0.
- R5: A write access (`acc_write`=1) at any step sets `seq_step` to 0 and raises no request. Reads that continue the pattern after that write do not complete it.
- R6: A read of any address other than the expected one sets `seq_step` to 0 and raises no request. The one exception is 0x0000, which sets `seq_step` to 1.
- R7: An access with `busy_hold`=1 is ignored. Read or write, it leaves `seq_step` unchanged and raises no request.
- R8: `nv_lock` rises together with either request pulse and stays high until the clock after `nv_done`. While it is high, every access is ignored.
- R9: `store_req` and `recall_req` are never high together, and neither stays high for two consecutive clocks.
- R10: `nv_done` sets `seq_step` to 0 and clears `nv_lock` on the next clock, whether or not a cycle was in progress. It takes priority over an access in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | One-clock strobe per chip-enable-controlled access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W (13) | Access address |
| busy_hold | input | 1 | Store-busy line asserted; accesses are not valid array cycles |
| nv_done | input | 1 | Nonvolatile engine finished its cycle |
| store_req | output | 1 | One-clock store request pulse |
| recall_req | output | 1 | One-clock recall request pulse |
| seq_step | output | 3 | Number of pattern steps accepted so far (0..5) |
| nv_lock | output | 1 | Array port disabled while a transfer runs |

## Verification
The bound checker enforces, on every clock, the properties that follow from single-cycle relations:
- request pulses are mutually exclusive and one clock wide;
- every pulse coincides with the lock;
- `seq_step` stays in range and is zero under the lock;
- busy-held accesses and writes have the stated effect;
- each store or recall pulse is traced back to a qualifying sixth read at step 5.

Other behaviours depend on a whole history of accesses and only the bench scenarios can show them. These are the exact prefix order, the restart on 0x0000, and the fact that a later correct tail cannot revive an aborted pattern. The bench sweeps every 13-bit address as the first access and as the sixth access.

// File: rtl/nvc_pkg.sv
`timescale 1ns/1ps
package nvc_pkg;

  localparam int KEY_W    = 13;
  localparam int PREFIX_N = 5;
  localparam int STEP_N   = PREFIX_N + 1;
  localparam int STEP_W   = $clog2(STEP_N);

  typedef logic [KEY_W-1:0] key_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  localparam key_t KEY_STORE  = 13'h0F0F;
  localparam key_t KEY_RECALL = 13'h0F0E;

  // Shared prefix of the unlock pattern, indexed by step number.
  function automatic key_t prefix_key(input int idx);
    key_t k;
    case (idx)
      0:       k = 13'h0000;
      1:       k = 13'h1555;
      2:       k = 13'h0AAA;
      3:       k = 13'h1FFF;
      4:       k = 13'h10F0;
      default: k = 13'h0000;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/nvc_qualify.sv
`timescale 1ns/1ps
module nvc_qualify (
  input  logic acc_valid,
  input  logic acc_write,
  input  logic busy_hold,
  input  logic nv_lock,
  output logic rd_ev,
  output logic wr_ev
);

  logic live;

  // An access counts only when the store-busy line is free and no transfer runs.
  assign live  = acc_valid & ~busy_hold & ~nv_lock;
  assign rd_ev = live & ~acc_write;
  assign wr_ev = live &  acc_write;

endmodule

// File: rtl/nvc_match.sv
`timescale 1ns/1ps
module nvc_match #(
  parameter int ADDR_W = nvc_pkg::KEY_W,
  parameter int STEP_W = nvc_pkg::STEP_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] step,
  output logic              adv,
  output logic              is_start,
  output nvc_pkg::cmd_e     cmd
);
  import nvc_pkg::*;

  logic [PREFIX_N-1:0] pre_hit;

  genvar gi;
  generate
    for (gi = 0; gi < PREFIX_N; gi++) begin : g_pre
      assign pre_hit[gi] = (addr == ADDR_W'(prefix_key(gi)));
    end
  endgenerate

  assign is_start = pre_hit[0];

  always_comb begin
    adv = 1'b0;
    for (int i = 0; i < PREFIX_N; i++) begin
      if (step == STEP_W'(i)) adv = pre_hit[i];
    end
  end

  always_comb begin
    cmd = CMD_NONE;
    if (step == STEP_W'(PREFIX_N)) begin
      if (addr == ADDR_W'(KEY_STORE))       cmd = CMD_STORE;
      else if (addr == ADDR_W'(KEY_RECALL)) cmd = CMD_RECALL;
    end
  end

endmodule

// File: rtl/nvc_seq.sv
`timescale 1ns/1ps
module nvc_seq #(
  parameter int STEP_W = nvc_pkg::STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ev,
  input  logic              wr_ev,
  input  logic              done,
  input  logic              adv,
  input  logic              is_start,
  input  nvc_pkg::cmd_e     cmd,
  output logic [STEP_W-1:0] step,
  output logic              store_req,
  output logic              recall_req,
  output logic              fire
);
  import nvc_pkg::*;

  logic [STEP_W-1:0] step_nxt;
  logic              st_nxt;
  logic              rc_nxt;

  always_comb begin
    step_nxt = step;
    st_nxt   = 1'b0;
    rc_nxt   = 1'b0;
    if (done) begin
      step_nxt = '0;
    end else if (wr_ev) begin
      step_nxt = '0;
    end else if (rd_ev) begin
      if (step == STEP_W'(PREFIX_N)) begin
        if (cmd != CMD_NONE) begin
          st_nxt   = (cmd == CMD_STORE);
          rc_nxt   = (cmd == CMD_RECALL);
          step_nxt = '0;
        end else begin
          step_nxt = is_start ? STEP_W'(1) : '0;
        end
      end else if (adv) begin
        step_nxt = step + STEP_W'(1);
      end else begin
        step_nxt = is_start ? STEP_W'(1) : '0;
      end
    end
  end

  assign fire = st_nxt | rc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      step       <= step_nxt;
      store_req  <= st_nxt;
      recall_req <= rc_nxt;
    end
  end

endmodule

// File: rtl/nvc_lock.sv
`timescale 1ns/1ps
module nvc_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic done,
  output logic lock
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lock <= 1'b0;
    else if (fire) lock <= 1'b1;
    else if (done) lock <= 1'b0;
  end

endmodule

// File: rtl/nvc_detect.sv
`timescale 1ns/1ps
module nvc_detect #(
  parameter int ADDR_W = nvc_pkg::KEY_W,
  localparam int STEP_W = nvc_pkg::STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              busy_hold,
  input  logic              nv_done,
  output logic              store_req,
  output logic              recall_req,
  output logic [STEP_W-1:0] seq_step,
  output logic              nv_lock
);

  logic          rd_ev;
  logic          wr_ev;
  logic          adv;
  logic          is_start;
  logic          fire;
  nvc_pkg::cmd_e cmd;

  nvc_qualify u_qual (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .busy_hold (busy_hold),
    .nv_lock   (nv_lock),
    .rd_ev     (rd_ev),
    .wr_ev     (wr_ev)
  );

  nvc_match #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_match (
    .addr     (acc_addr),
    .step     (seq_step),
    .adv      (adv),
    .is_start (is_start),
    .cmd      (cmd)
  );

  nvc_seq #(.STEP_W(STEP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ev      (rd_ev),
    .wr_ev      (wr_ev),
    .done       (nv_done),
    .adv        (adv),
    .is_start   (is_start),
    .cmd        (cmd),
    .step       (seq_step),
    .store_req  (store_req),
    .recall_req (recall_req),
    .fire       (fire)
  );

  nvc_lock u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .done  (nv_done),
    .lock  (nv_lock)
  );

endmodule

// File: rtl/nvc_checker.sv
`timescale 1ns/1ps
module nvc_checker #(
  parameter int ADDR_W = nvc_pkg::KEY_W,
  parameter int STEP_W = nvc_pkg::STEP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              busy_hold,
  input logic              nv_done,
  input logic              store_req,
  input logic              recall_req,
  input logic [STEP_W-1:0] seq_step,
  input logic              nv_lock
);
  import nvc_pkg::*;

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_step <= STEP_W'(PREFIX_N)); // R2

  AST_STORE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(acc_valid && !acc_write && !busy_hold && !nv_done &&
                        acc_addr == ADDR_W'(KEY_STORE) &&
                        seq_step == STEP_W'(PREFIX_N))); // R3

  AST_RECALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(acc_valid && !acc_write && !busy_hold && !nv_done &&
                         acc_addr == ADDR_W'(KEY_RECALL) &&
                         seq_step == STEP_W'(PREFIX_N))); // R4

  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !busy_hold && !nv_lock) |=>
      (seq_step == '0 && !store_req && !recall_req)); // R5

  AST_HOLD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && busy_hold && !nv_done) |=>
      ($stable(seq_step) && !store_req && !recall_req)); // R7

  AST_PULSE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> nv_lock); // R8

  AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_lock |-> (seq_step == '0)); // R8

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req)); // R9

  AST_STORE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req); // R9

  AST_RECALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_done |=> (seq_step == '0 && !nv_lock)); // R10

endmodule

bind nvc_detect nvc_checker #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_addr   (acc_addr),
  .busy_hold  (busy_hold),
  .nv_done    (nv_done),
  .store_req  (store_req),
  .recall_req (recall_req),
  .seq_step   (seq_step),
  .nv_lock    (nv_lock)
);

// File: tb/nvc_detect_tb.sv
`timescale 1ns/1ps
module nvc_detect_tb;

  localparam logic [12:0] KEYS [0:5] = '{13'h0000, 13'h1555, 13'h0AAA,
                                         13'h1FFF, 13'h10F0, 13'h0F0F};
  localparam logic [12:0] RCL = 13'h0F0E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [12:0] acc_addr = '0;
  logic        busy_hold = 1'b0;
  logic        nv_done = 1'b0;
  logic        store_req;
  logic        recall_req;
  logic [2:0]  seq_step;
  logic        nv_lock;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nvc_detect u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .busy_hold  (busy_hold),
    .nv_done    (nv_done),
    .store_req  (store_req),
    .recall_req (recall_req),
    .seq_step   (seq_step),
    .nv_lock    (nv_lock)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic acc(input logic [12:0] a, input logic w, input logic h);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; busy_hold = h;
    @(negedge clk);
  endtask

  task automatic idle();
    acc_valid = 1'b0; acc_write = 1'b0; busy_hold = 1'b0;
    @(negedge clk);
  endtask

  task automatic done_pulse();
    acc_valid = 1'b0; acc_write = 1'b0; busy_hold = 1'b0; nv_done = 1'b1;
    @(negedge clk);
    nv_done = 1'b0;
  endtask

  task automatic prefix(input int n);
    for (int i = 0; i < n; i++) acc(KEYS[i], 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 step", seq_step, 0);
    chk("R1 store", store_req, 0);
    chk("R1 recall", recall_req, 0);
    chk("R1 lock", nv_lock, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full store pattern
    for (int i = 0; i < 5; i++) begin
      acc(KEYS[i], 1'b0, 1'b0);
      chk("R2 step", seq_step, i + 1);
    end
    acc(KEYS[5], 1'b0, 1'b0);
    chk("R3 store", store_req, 1);
    chk("R3 recall", recall_req, 0);
    chk("R3 step", seq_step, 0);
    chk("R8 lock", nv_lock, 1);
    idle();
    chk("R9 store one", store_req, 0);
    chk("R8 lock held", nv_lock, 1);
    prefix(2);
    chk("R8 locked step", seq_step, 0);
    idle();
    done_pulse();
    chk("R8 unlock", nv_lock, 0);
    chk("R10 step", seq_step, 0);

    // Recall pattern
    prefix(5);
    acc(RCL, 1'b0, 1'b0);
    chk("R4 recall", recall_req, 1);
    chk("R9 excl", store_req, 0);
    chk("R4 step", seq_step, 0);
    idle();
    chk("R9 recall one", recall_req, 0);
    done_pulse();

    // Store regardless of write history; idle gaps between steps
    acc(13'h0123, 1'b1, 1'b0);
    idle();
    for (int i = 0; i < 5; i++) begin
      acc(KEYS[i], 1'b0, 1'b0);
      idle();
      chk("R2 gap step", seq_step, i + 1);
    end
    acc(KEYS[5], 1'b0, 1'b0);
    chk("R3 unconditional", store_req, 1);
    done_pulse();

    // Write abort at each position
    for (int p = 1; p < 6; p++) begin
      prefix(p);
      acc(KEYS[p], 1'b1, 1'b0);
      chk("R5 write abort", seq_step, 0);
      for (int j = p; j < 6; j++) acc(KEYS[j], 1'b0, 1'b0);
      chk("R5 no store", store_req, 0);
      chk("R5 no recall", recall_req, 0);
      done_pulse();
    end

    // Wrong read abort at each position
    for (int p = 0; p < 6; p++) begin
      prefix(p);
      acc(KEYS[p] ^ 13'h0100, 1'b0, 1'b0);
      chk("R6 wrong read", seq_step, 0);
      chk("R6 no pulse", store_req | recall_req, 0);
      done_pulse();
    end

    // Restart with 0x0000 at each position
    for (int p = 1; p < 6; p++) begin
      prefix(p);
      acc(13'h0000, 1'b0, 1'b0);
      chk("R6 restart", seq_step, 1);
      for (int j = 1; j < 6; j++) acc(KEYS[j], 1'b0, 1'b0);
      chk("R6 restart store", store_req, 1);
      done_pulse();
    end

    // Busy-held accesses ignored at each position
    for (int p = 0; p < 6; p++) begin
      prefix(p);
      acc(KEYS[p], 1'b0, 1'b1);
      chk("R7 hold read", seq_step, p);
      chk("R7 hold no pulse", store_req, 0);
      acc(13'h0055, 1'b1, 1'b1);
      chk("R7 hold write", seq_step, p);
      for (int j = p; j < 6; j++) acc(KEYS[j], 1'b0, 1'b0);
      chk("R7 resume store", store_req, 1);
      done_pulse();
    end

    // Completion while unlocked; done beats a same-cycle access
    prefix(3);
    chk("R2 mid", seq_step, 3);
    done_pulse();
    chk("R10 unlocked done", seq_step, 0);
    chk("R10 lock", nv_lock, 0);
    prefix(4);
    acc_valid = 1'b1; acc_addr = KEYS[4]; nv_done = 1'b1;
    @(negedge clk);
    nv_done = 1'b0;
    chk("R10 priority", seq_step, 0);
    idle();

    // Exhaustive first access from idle
    for (int a = 0; a < 8192; a++) begin
      acc(13'(a), 1'b0, 1'b0);
      chk("R6 first sweep", seq_step, (a == 0) ? 1 : 0);
      done_pulse();
    end

    // Exhaustive sixth access
    for (int a = 0; a < 8192; a++) begin
      prefix(5);
      acc(13'(a), 1'b0, 1'b0);
      chk("R3 sweep store", store_req, (a == 13'h0F0F) ? 1 : 0);
      chk("R4 sweep recall", recall_req, (a == 13'h0F0E) ? 1 : 0);
      chk("R6 sweep step", seq_step, (a == 0) ? 1 : 0);
      done_pulse();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule